// File: doc/BRIEF.md
# Sequenced-Arm Watchdog Timer

This block is a watchdog timer for a system that must be reset if software stops servicing it. An up-counter advances on a slow tick strobe, optionally divided by a power-of-two prescaler. When the armed counter rolls over from its all-ones value to zero, the block fires a one-cycle reset pulse and latches a sticky cause flag. Software keeps the system alive by writing a new value to the trigger register, which reloads the counter from the load register.

Arming and disarming need two particular words written back to back to the arm register. A stray single write therefore cannot start or stop the timer. Every register write is posted: it is held in a per-register slot, reported as pending in a status register, and applied only after a fixed crossing delay. Software polls the pending bit before it issues the next write to the same register. While the timer runs, writes to control and load have no effect, so the timeout cannot be changed under a live watchdog.

Top module: `wdt_seqarm`

## Requirements
- R1: Word address map: 0 revision, 1 control, 2 load, 3 counter, 4 trigger, 5 arm, 6 pending status. After reset the counter, control, load and pending status read 0, the timer is disarmed, `wdog_rst` and `rst_cause` are 0, and the low byte of the revision word reads `REV_CODE` (default 0x21).
- R2: The value 0x0000BBBB followed by 0x00004444, both taking effect at the arm register, arms the timer. The arm register reads back the last word that took effect.
- R3: The value 0x0000AAAA followed by 0x00005555 disarms the timer. A disarmed counter holds its value whatever the tick does.
- R4: If the word that follows 0xBBBB or 0xAAAA is not the matching second word, the pair is discarded and the armed state stays as it was.
- R5: A trigger write whose value differs from the stored trigger value copies the load register into the counter. A trigger write equal to the stored value leaves the counter untouched.
- R6: Pending status bit 0 belongs to control, bit 2 to load, bit 3 to trigger and bit 4 to arm. A write sets its bit in the clock edge that accepts it. The bit reads 1 for exactly `SYNC_DLY` cycles (default 3) and clears in the edge where the write takes effect.
- R7: While armed, writes to control and load take no effect, and their readback is unchanged.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold the ratio r. With the prescaler enabled, the armed counter advances once every 2^r ticks, counted from arming or reload. With it disabled, the counter advances on every tick.
- R9: When the armed counter wraps from all ones to 0, `wdog_rst` is high for exactly one cycle, in the cycle after the wrapping tick edge, and `rst_cause` becomes 1 and stays 1 until reset.
- R10: A write to a register whose pending bit is still set is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe per slow tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdog_rst | output | 1 | One-cycle reset pulse on armed overflow |
| rst_cause | output | 1 | Sticky flag: a watchdog reset has fired |

## Verification
The bench counts the cycles that each pending bit stays set. It also writes to a register whose pending bit is still set, which exposes a design that applies writes early, late, or twice. It breaks arm and disarm pairs with wrong second words, and it repeats a trigger value, to catch a sequencer that acts on half a sequence or a reload that ignores the stored trigger value. A sweep over every prescaler ratio samples the counter one tick before and one tick after each advance, and so detects an off-by-one divider. The overflow test checks a reset pulse that is too long, fires at the wrong moment, or fails to set the sticky cause flag.

// File: rtl/wdt_seqarm_pkg.sv
package wdt_seqarm_pkg;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned NSLOT    = 4;

   // word addresses
   localparam int unsigned A_REV    = 0;
   localparam int unsigned A_CTRL   = 1;
   localparam int unsigned A_LOAD   = 2;
   localparam int unsigned A_COUNT  = 3;
   localparam int unsigned A_TRIG   = 4;
   localparam int unsigned A_ARM    = 5;
   localparam int unsigned A_PEND   = 6;

   // posting slot indices
   localparam int unsigned S_CTRL   = 0;
   localparam int unsigned S_LOAD   = 1;
   localparam int unsigned S_TRIG   = 2;
   localparam int unsigned S_ARM    = 3;

   // control field positions
   localparam int unsigned C_PRE_EN = 5;
   localparam int unsigned C_RAT_LO = 2;
   localparam int unsigned RATIO_W  = 3;

   // arm sequence words
   localparam logic [DATA_W-1:0] ARM_ON_A  = 32'h0000_BBBB;
   localparam logic [DATA_W-1:0] ARM_ON_B  = 32'h0000_4444;
   localparam logic [DATA_W-1:0] ARM_OFF_A = 32'h0000_AAAA;
   localparam logic [DATA_W-1:0] ARM_OFF_B = 32'h0000_5555;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ON_HALF,
      SQ_OFF_HALF
   } seq_state_e;

   function automatic int unsigned slot_addr(input int unsigned s);
      case (s)
         S_CTRL:  return A_CTRL;
         S_LOAD:  return A_LOAD;
         S_TRIG:  return A_TRIG;
         default: return A_ARM;
      endcase
   endfunction

   function automatic int unsigned slot_pbit(input int unsigned s);
      case (s)
         S_CTRL:  return 0;
         S_LOAD:  return 2;
         S_TRIG:  return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
   parameter int unsigned DW  = 32,
   parameter int unsigned DLY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          pend,
   output logic          commit,
   output logic [DW-1:0] cdata
);
   localparam int unsigned DCW = $clog2(DLY + 1);

   logic [DCW-1:0] dly_q;
   logic [DW-1:0]  data_q;

   assign pend   = (dly_q != '0);
   assign commit = (dly_q == DCW'(1));
   assign cdata  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q  <= '0;
         data_q <= '0;
      end else if (wr && !pend) begin
         dly_q  <= DCW'(DLY);
         data_q <= wdata;
      end else if (pend) begin
         dly_q  <= dly_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_arm_seq.sv
module wdt_arm_seq
   import wdt_seqarm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [DATA_W-1:0] word,
   output logic              armed,
   output logic [DATA_W-1:0] last_word
);
   seq_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         armed     <= 1'b0;
         last_word <= '0;
      end else if (commit) begin
         last_word <= word;
         case (st_q)
            SQ_IDLE: begin
               if (word == ARM_ON_A)       st_q <= SQ_ON_HALF;
               else if (word == ARM_OFF_A) st_q <= SQ_OFF_HALF;
            end
            SQ_ON_HALF: begin
               if (word == ARM_ON_B) armed <= 1'b1;
               st_q <= SQ_IDLE;
            end
            SQ_OFF_HALF: begin
               if (word == ARM_OFF_B) armed <= 1'b0;
               st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wdt_tick_cnt.sv
module wdt_tick_cnt #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned RATIO_W = 3,
   parameter bit          HAS_PRE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               armed,
   input  logic               tick,
   input  logic               pre_en,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               reload,
   input  logic [CNT_W-1:0]   reload_val,
   output logic [CNT_W-1:0]   cnt,
   output logic               wrap
);
   localparam int unsigned PRE_W = (1 << RATIO_W) - 1;

   logic adv;

   generate
      if (HAS_PRE) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] lim;
         logic             hit;

         assign lim = (PRE_W'(1) << ratio) - PRE_W'(1);
         assign hit = !pre_en || (pre_q == lim);
         assign adv = armed && tick && hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (reload || !armed) pre_q <= '0;
            else if (tick)             pre_q <= hit ? '0 : pre_q + 1'b1;
         end
      end else begin : g_nopre
         assign adv = armed && tick;
      end
   endgenerate

   assign wrap = adv && !reload && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (reload) cnt <= reload_val;
      else if (adv)    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdt_seqarm.sv
module wdt_seqarm
   import wdt_seqarm_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned SYNC_DLY = 3,
   parameter int unsigned ADDR_W   = 3,
   parameter logic [7:0]  REV_CODE = 8'h21,
   parameter bit          HAS_PRE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdog_rst,
   output logic              rst_cause
);
   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdt_seqarm: CNT_W must lie in 8..32");
      end
      if (SYNC_DLY < 1 || SYNC_DLY > 15) begin : g_bad_dly
         $error("wdt_seqarm: SYNC_DLY must lie in 1..15");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("wdt_seqarm: ADDR_W must be at least 3");
      end
   endgenerate

   logic              slot_wr [NSLOT];
   logic              pend    [NSLOT];
   logic              commit  [NSLOT];
   logic [DATA_W-1:0] cdata   [NSLOT];

   genvar gs;
   generate
      for (gs = 0; gs < NSLOT; gs++) begin : g_slot
         assign slot_wr[gs] = bus_we && (bus_addr == ADDR_W'(slot_addr(gs)));
         wdt_post_slot #(.DW(DATA_W), .DLY(SYNC_DLY)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (slot_wr[gs]),
            .wdata  (bus_wdata),
            .pend   (pend[gs]),
            .commit (commit[gs]),
            .cdata  (cdata[gs])
         );
      end
   endgenerate

   logic              armed;
   logic [DATA_W-1:0] arm_last;

   wdt_arm_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit[S_ARM]),
      .word      (cdata[S_ARM]),
      .armed     (armed),
      .last_word (arm_last)
   );

   logic [DATA_W-1:0] ctrl_q, load_q, trig_q;
   logic              reload;

   assign reload = commit[S_TRIG] && (cdata[S_TRIG] != trig_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         trig_q <= '0;
      end else begin
         if (commit[S_CTRL] && !armed) ctrl_q <= cdata[S_CTRL];
         if (commit[S_LOAD] && !armed) load_q <= cdata[S_LOAD];
         if (reload)                   trig_q <= cdata[S_TRIG];
      end
   end

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   wdt_tick_cnt #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .HAS_PRE(HAS_PRE)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (armed),
      .tick       (tick_en),
      .pre_en     (ctrl_q[C_PRE_EN]),
      .ratio      (ctrl_q[C_RAT_LO +: RATIO_W]),
      .reload     (reload),
      .reload_val (load_q[CNT_W-1:0]),
      .cnt        (cnt_q),
      .wrap       (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdog_rst  <= 1'b0;
         rst_cause <= 1'b0;
      end else begin
         wdog_rst  <= wrap;
         rst_cause <= rst_cause | wrap;
      end
   end

   logic [DATA_W-1:0] pend_word;

   always_comb begin
      pend_word = '0;
      for (int s = 0; s < NSLOT; s++) pend_word[slot_pbit(s)] = pend[s];
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_REV):   bus_rdata = {24'h0, REV_CODE};
         ADDR_W'(A_CTRL):  bus_rdata = ctrl_q;
         ADDR_W'(A_LOAD):  bus_rdata = load_q;
         ADDR_W'(A_COUNT): bus_rdata = DATA_W'(cnt_q);
         ADDR_W'(A_TRIG):  bus_rdata = trig_q;
         ADDR_W'(A_ARM):   bus_rdata = arm_last;
         ADDR_W'(A_PEND):  bus_rdata = pend_word;
         default:          bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_seqarm_chk.sv
module wdt_seqarm_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdog_rst,
   input logic              rst_cause,
   input logic              armed,
   input logic              reload,
   input logic              ctrl_commit,
   input logic [31:0]       ctrl_q,
   input logic [31:0]       pend_word,
   input logic [CNT_W-1:0]  cnt_q
);
   // R9
   rst_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> !wdog_rst);

   // R9
   cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> rst_cause);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !reload) |=> $stable(cnt_q));

   // R8
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !reload) |=> $stable(cnt_q));

   // R7
   ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ctrl_commit) |=> $stable(ctrl_q));

   // R6
   load_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(2) && !pend_word[2]) |=> pend_word[2]);
endmodule

bind wdt_seqarm wdt_seqarm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .wdog_rst    (wdog_rst),
   .rst_cause   (rst_cause),
   .armed       (armed),
   .reload      (reload),
   .ctrl_commit (commit[0]),
   .ctrl_q      (ctrl_q),
   .pend_word   (pend_word),
   .cnt_q       (cnt_q)
);

// File: tb/test_wdt_seqarm.sv
`timescale 1ns/1ps
module test_wdt_seqarm;
   localparam int SD = 3;
   localparam int AREV = 0, ACTRL = 1, ALOAD = 2, ACNT = 3, ATRIG = 4, AARM = 5, APEND = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdog_rst, rst_cause;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] tpat = 32'h1234;

   always #4 clk = ~clk;

   wdt_seqarm i_wdt_seqarm (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdog_rst(wdog_rst), .rst_cause(rst_cause)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int pbit(input int a);
      case (a)
         ACTRL:   return 0;
         ALOAD:   return 2;
         ATRIG:   return 3;
         default: return 4;
      endcase
   endfunction

   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = 3'(a);
      #1 v = bus_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic settle(input int a, output int n);
      logic [31:0] v;
      n = 0;
      rd(APEND, v);
      while (v[pbit(a)] && n < 50) begin
         @(negedge clk);
         n++;
         rd(APEND, v);
      end
   endtask

   task automatic wrs(input int a, input logic [31:0] d);
      int n;
      wr(a, d);
      settle(a, n);
   endtask

   task automatic tick();
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) tick();
   endtask

   task automatic arm();    wrs(AARM, 32'hBBBB); wrs(AARM, 32'h4444); endtask
   task automatic disarm(); wrs(AARM, 32'hAAAA); wrs(AARM, 32'h5555); endtask
   task automatic trig();   tpat = ~tpat; wrs(ATRIG, tpat); endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n;
      int regs [4];
      logic [31:0] vals [4];
      regs = '{ACTRL, ALOAD, ATRIG, AARM};
      vals = '{32'h0, 32'd100, ~tpat, 32'h77};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(AREV, v);  chk("R1 revision", {24'h0, v[7:0]}, 32'h21);
      rd(ACNT, v);  chk("R1 counter", v, 0);
      rd(APEND, v); chk("R1 pending", v, 0);
      rd(ACTRL, v); chk("R1 control", v, 0);
      rd(ALOAD, v); chk("R1 load", v, 0);
      chk("R1 wdog_rst", {31'h0, wdog_rst}, 0);
      chk("R1 rst_cause", {31'h0, rst_cause}, 0);

      // R6 pending bit position and duration for each register
      for (int i = 0; i < 4; i++) begin
         wr(regs[i], vals[i]);
         rd(APEND, v);
         chk("R6 pending bit set", v, 32'(1) << pbit(regs[i]));
         settle(regs[i], n);
         chk("R6 pending cycles", n, SD);
      end
      tpat = vals[2];
      rd(ALOAD, v); chk("R6 load applied", v, 100);
      rd(ACNT, v);  chk("R5 reload from load", v, 100);

      // R10 write while pending is dropped
      wr(ALOAD, 200);
      wr(ALOAD, 300);
      settle(ALOAD, n);
      rd(ALOAD, v); chk("R10 second write dropped", v, 200);

      // R3 disarmed counter holds
      ticks(5);
      rd(ACNT, v); chk("R3 disarmed hold", v, 100);

      // R2 arming
      arm();
      rd(AARM, v); chk("R2 arm readback", v, 32'h4444);
      ticks(5);
      rd(ACNT, v); chk("R2 armed counts", v, 105);

      // R7 control and load locked while armed
      wrs(ACTRL, 32'h3C);
      rd(ACTRL, v); chk("R7 control locked", v, 0);
      wrs(ALOAD, 7);
      rd(ALOAD, v); chk("R7 load locked", v, 200);
      tick();
      rd(ACNT, v); chk("R7 still every tick", v, 106);

      // R5 repeated trigger value does nothing, new value reloads
      wrs(ATRIG, tpat);
      rd(ACNT, v); chk("R5 same trigger no reload", v, 106);
      trig();
      rd(ACNT, v); chk("R5 new trigger reloads", v, 200);

      // R4 broken stop pair keeps timer armed
      wrs(AARM, 32'hAAAA); wrs(AARM, 32'h1234);
      tick();
      rd(ACNT, v); chk("R4 broken stop ignored", v, 201);

      // R3 proper stop pair
      disarm();
      tick();
      rd(ACNT, v); chk("R3 stopped", v, 201);

      // R4 broken start pair keeps timer disarmed
      wrs(AARM, 32'hBBBB); wrs(AARM, 32'h9999);
      tick();
      rd(ACNT, v); chk("R4 broken start ignored", v, 201);

      // R8 prescaler sweep over every ratio
      for (int r = 0; r < 8; r++) begin
         wrs(ACTRL, 32'h20 | (32'(r) << 2));
         wrs(ALOAD, 1000);
         trig();
         arm();
         ticks(4 * (1 << r) - 1);
         rd(ACNT, v); chk($sformatf("R8 ratio %0d before step", r), v, 1003);
         tick();
         rd(ACNT, v); chk($sformatf("R8 ratio %0d after step", r), v, 1004);
         disarm();
      end
      // R8 prescaler disabled: every tick
      wrs(ACTRL, 32'h5 << 2);
      trig();
      arm();
      ticks(3);
      rd(ACNT, v); chk("R8 prescaler off", v, 1003);
      disarm();

      // R9 overflow
      wrs(ACTRL, 0);
      wrs(ALOAD, 32'hFFFF_FFFE);
      trig();
      arm();
      tick();
      rd(ACNT, v); chk("R9 at all ones", v, 32'hFFFF_FFFF);
      chk("R9 no pulse yet", {31'h0, wdog_rst}, 0);
      chk("R9 no cause yet", {31'h0, rst_cause}, 0);
      tick();
      rd(ACNT, v); chk("R9 wrapped", v, 0);
      chk("R9 pulse high", {31'h0, wdog_rst}, 1);
      chk("R9 cause set", {31'h0, rst_cause}, 1);
      @(negedge clk);
      chk("R9 pulse one cycle", {31'h0, wdog_rst}, 0);
      chk("R9 cause sticky", {31'h0, rst_cause}, 1);
      tick();
      rd(ACNT, v); chk("R9 keeps counting", v, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule